// File: doc/BRIEF.md
# CPU Effective Address Generator

This block forms the 24-bit operand address for a processor whose general registers are 16 bits wide and whose program and data banks are separate 8-bit registers. The decoder presents a mode code, the operand bytes already fetched after the opcode, and the current register file values. The block then returns the effective address, the number of bytes the program counter must advance, and the number of extra internal cycles that the mode costs.

Most modes are pure arithmetic. These modes finish one cycle after the request. The indirect modes first fetch a 2-byte or 3-byte pointer through a byte-wide read port. Each byte is requested in turn and held until the memory acknowledges it. Each mode has its own wrap rule:
- Direct-page and stack sums stay within 16 bits in bank 0.
- Absolute-indexed sums may carry into the bank byte.
- Long sums wrap at 24 bits.

`opnd_i[7:0]` holds the first operand byte, `[15:8]` the second and `[23:16]` the third. `pc_i` is the address of the first operand byte.

Top module: `ea_gen`

## Requirements
- R1: Immediate modes give `ea_o` = {PB, PC}. Mode 0 (8-bit operand) reports `pc_inc_o`=1 and mode 1 (16-bit operand) reports 2. Any mode code from 22 to 31 behaves as mode 0.
- R2: Mode 2 is the short branch. Its target is {PB, (PC+1+sign-extended byte0) mod 2^16} and it reports `pc_inc_o`=1. Mode 3 is the long branch. Its target is {PB, (PC+2+opnd[15:0]) mod 2^16} and it reports `pc_inc_o`=2.
- R3: Mode 4 gives {0x00, (D+byte0) mod 2^16}. Modes 5 and 6 also add X or Y inside the same 16-bit wrap and report `extra_cyc_o`=1. All three report `pc_inc_o`=1.
- R4: Mode 7 gives {DB, opnd[15:0]}. Modes 8 and 9 add X or Y to that 24-bit value, so a carry enters the bank byte, and the sum wraps at 24 bits. All three report `pc_inc_o`=2.
- R5: Mode 10 gives opnd[23:0]. Mode 11 gives (opnd[23:0]+X) mod 2^24. Both report `pc_inc_o`=3.
- R6: Mode 20 gives {0x00, (S+byte0) mod 2^16}, with `extra_cyc_o`=1 and `pc_inc_o`=1.
- R7: Pointer reads work as follows:
  - Bytes are read little-endian, one per request, with `mem_rd_o` high.
  - Each address and request is held until `mem_valid_i` is seen.
  - The next byte's address is the previous one plus 1, where the low 16 bits wrap and the bank stays fixed.
  - No read is issued while idle.
- R8: Mode 12 reads 2 bytes at {PB, (opnd[15:0]+X) mod 2^16} and gives {PB, ptr}. Mode 13 reads 2 bytes at {0x00, opnd[15:0]} and gives {PB, ptr}. Mode 14 reads 3 bytes at {0x00, opnd[15:0]} and gives ptr. All three report `pc_inc_o`=2.
- R9: The pointer address for modes 15 to 18 is {0x00, (D+byte0) mod 2^16}. Mode 19 uses {0x00, (D+byte0+X) mod 2^16} and reports `extra_cyc_o`=1. The results are:
  - Mode 15 and mode 19 give {DB, ptr16}.
  - Mode 16 gives ({DB, ptr16}+Y) mod 2^24.
  - Mode 17 gives the 3-byte ptr.
  - Mode 18 gives (ptr24+Y) mod 2^24.
  - All of modes 15 to 19 report `pc_inc_o`=1.
- R10: Mode 21 reads 2 bytes at {0x00, (S+byte0) mod 2^16} and gives ({DB, ptr16}+Y) mod 2^24, with `extra_cyc_o`=2 and `pc_inc_o`=1. Every mode not named in R3, R6, R9 or R10 reports `extra_cyc_o`=0.
- R11: A request is taken only while `ready_o` is high, and `ready_o` is low during a pointer fetch. A request raised while busy has no effect. `done_o` pulses for exactly one cycle, either in the cycle after the request is accepted (non-indirect modes) or in the cycle after the last pointer byte is acknowledged. `ea_o`, `pc_inc_o` and `extra_cyc_o` are valid while `done_o` is high and are held until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start request |
| mode_i | input | 5 | Addressing mode code |
| opnd_i | input | 24 | Operand bytes, first byte in bits 7:0 |
| pc_i | input | 16 | Address of the first operand byte |
| pb_i | input | 8 | Program bank |
| db_i | input | 8 | Data bank |
| d_i | input | 16 | Direct-page base |
| s_i | input | 16 | Stack pointer |
| x_i | input | 16 | X index |
| y_i | input | 16 | Y index |
| ready_o | output | 1 | Idle, can accept a request |
| done_o | output | 1 | One-cycle result strobe |
| ea_o | output | 24 | Effective address |
| pc_inc_o | output | 2 | Program counter advance in bytes |
| extra_cyc_o | output | 2 | Extra internal cycles for the mode |
| mem_rd_o | output | 1 | Pointer byte read request |
| mem_addr_o | output | 24 | Pointer byte address |
| mem_rdata_i | input | 8 | Pointer byte data |
| mem_valid_i | input | 1 | Pointer byte acknowledge |

## Verification
Each mode code is driven with ordinary values and with values at a wrap boundary:
- D or S near 0xFFFF separates a 16-bit wrap from a carry into the bank.
- Absolute-indexed operands that overflow 16 bits prove that the carry does reach the bank.
- Long operands near 0xFFFFFF expose the 24-bit wrap.
- Negative short branches and long branch overflow check sign extension and truncation.

Indirect modes are run with acknowledge latencies of zero, one and three cycles, which separates request holding from byte ordering. One pointer sits at 0xFFFF to show that the byte address wraps inside its bank. A request pulse is raised during a fetch to show that a busy block ignores it.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int ADDR_W = 24;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int PTR_MAX = 3;

  typedef enum logic [4:0] {
    M_IMM8        = 5'd0,
    M_IMM16       = 5'd1,
    M_REL8        = 5'd2,
    M_REL16       = 5'd3,
    M_DIR         = 5'd4,
    M_DIR_X       = 5'd5,
    M_DIR_Y       = 5'd6,
    M_ABS         = 5'd7,
    M_ABS_X       = 5'd8,
    M_ABS_Y       = 5'd9,
    M_LONG        = 5'd10,
    M_LONG_X      = 5'd11,
    M_ABS_X_IND   = 5'd12,
    M_ABS_IND     = 5'd13,
    M_ABS_IND_L   = 5'd14,
    M_DIR_IND     = 5'd15,
    M_DIR_IND_Y   = 5'd16,
    M_DIR_IND_L   = 5'd17,
    M_DIR_IND_L_Y = 5'd18,
    M_DIR_X_IND   = 5'd19,
    M_STK         = 5'd20,
    M_STK_IND_Y   = 5'd21
  } ea_mode_e;

  typedef struct packed {
    logic [BYTE_W-1:0] pb;
    logic [BYTE_W-1:0] db;
    logic [WORD_W-1:0] y;
  } ea_ctx_t;
endpackage

// File: rtl/ea_pre.sv
module ea_pre
  import ea_pkg::*;
(
  input  ea_mode_e          mode_i,
  input  logic [ADDR_W-1:0] opnd_i,
  input  logic [WORD_W-1:0] pc_i,
  input  logic [BYTE_W-1:0] pb_i,
  input  logic [BYTE_W-1:0] db_i,
  input  logic [WORD_W-1:0] d_i,
  input  logic [WORD_W-1:0] s_i,
  input  logic [WORD_W-1:0] x_i,
  input  logic [WORD_W-1:0] y_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic              need_ptr_o,
  output logic [1:0]        ptr_len_o,
  output logic [ADDR_W-1:0] ptr_addr_o,
  output logic [1:0]        pc_inc_o,
  output logic [1:0]        extra_o
);
  logic [WORD_W-1:0] op8_z, op8_s, op16;
  logic [WORD_W-1:0] dir_sum, dir_x_sum, dir_y_sum, stk_sum, absx16;
  logic [WORD_W-1:0] rel8_t, rel16_t;
  logic [ADDR_W-1:0] abs_full;

  assign op8_z     = {8'h00, opnd_i[7:0]};
  assign op8_s     = {{8{opnd_i[7]}}, opnd_i[7:0]};
  assign op16      = opnd_i[15:0];
  assign dir_sum   = d_i + op8_z;
  assign dir_x_sum = dir_sum + x_i;
  assign dir_y_sum = dir_sum + y_i;
  assign stk_sum   = s_i + op8_z;
  assign absx16    = op16 + x_i;
  assign rel8_t    = pc_i + 16'd1 + op8_s;
  assign rel16_t   = pc_i + 16'd2 + op16;
  assign abs_full  = {db_i, op16};

  always_comb begin
    ea_o       = {pb_i, pc_i};
    need_ptr_o = 1'b0;
    ptr_len_o  = 2'd2;
    ptr_addr_o = '0;
    pc_inc_o   = 2'd1;
    extra_o    = 2'd0;
    unique case (mode_i)
      M_IMM16:   pc_inc_o = 2'd2;
      M_REL8:    ea_o = {pb_i, rel8_t};
      M_REL16: begin ea_o = {pb_i, rel16_t}; pc_inc_o = 2'd2; end
      M_DIR:     ea_o = {8'h00, dir_sum};
      M_DIR_X: begin ea_o = {8'h00, dir_x_sum}; extra_o = 2'd1; end
      M_DIR_Y: begin ea_o = {8'h00, dir_y_sum}; extra_o = 2'd1; end
      M_ABS:   begin ea_o = abs_full; pc_inc_o = 2'd2; end
      M_ABS_X: begin ea_o = abs_full + {8'h00, x_i}; pc_inc_o = 2'd2; end
      M_ABS_Y: begin ea_o = abs_full + {8'h00, y_i}; pc_inc_o = 2'd2; end
      M_LONG:  begin ea_o = opnd_i; pc_inc_o = 2'd3; end
      M_LONG_X: begin ea_o = opnd_i + {8'h00, x_i}; pc_inc_o = 2'd3; end
      M_ABS_X_IND: begin
        need_ptr_o = 1'b1; ptr_addr_o = {pb_i, absx16}; pc_inc_o = 2'd2;
      end
      M_ABS_IND: begin
        need_ptr_o = 1'b1; ptr_addr_o = {8'h00, op16}; pc_inc_o = 2'd2;
      end
      M_ABS_IND_L: begin
        need_ptr_o = 1'b1; ptr_addr_o = {8'h00, op16}; pc_inc_o = 2'd2;
        ptr_len_o = 2'd3;
      end
      M_DIR_IND, M_DIR_IND_Y: begin
        need_ptr_o = 1'b1; ptr_addr_o = {8'h00, dir_sum};
      end
      M_DIR_IND_L, M_DIR_IND_L_Y: begin
        need_ptr_o = 1'b1; ptr_addr_o = {8'h00, dir_sum}; ptr_len_o = 2'd3;
      end
      M_DIR_X_IND: begin
        need_ptr_o = 1'b1; ptr_addr_o = {8'h00, dir_x_sum}; extra_o = 2'd1;
      end
      M_STK: begin ea_o = {8'h00, stk_sum}; extra_o = 2'd1; end
      M_STK_IND_Y: begin
        need_ptr_o = 1'b1; ptr_addr_o = {8'h00, stk_sum}; extra_o = 2'd2;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ea_ptr_fetch.sv
module ea_ptr_fetch
  import ea_pkg::*;
#(
  parameter int NBYTES = PTR_MAX
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [ADDR_W-1:0]        base_i,
  input  logic [1:0]               len_i,
  input  logic                     mem_valid_i,
  input  logic [BYTE_W-1:0]        mem_rdata_i,
  output logic                     mem_rd_o,
  output logic [ADDR_W-1:0]        mem_addr_o,
  output logic                     fin_o,
  output logic [NBYTES*BYTE_W-1:0] ptr_o
);
  logic              active_q;
  logic [1:0]        idx_q, len_q;
  logic [ADDR_W-1:0] base_q;
  logic [BYTE_W-1:0] byte_q [NBYTES];
  logic [WORD_W-1:0] lo_addr;

  assign lo_addr    = base_q[WORD_W-1:0] + {14'd0, idx_q};
  assign mem_rd_o   = active_q;
  assign mem_addr_o = {base_q[ADDR_W-1:WORD_W], lo_addr};
  assign fin_o      = active_q && mem_valid_i && (idx_q == len_q - 2'd1);

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                              byte_q[g] <= '0;
      else if (start_i)                                         byte_q[g] <= '0;
      else if (active_q && mem_valid_i && idx_q == 2'(g))       byte_q[g] <= mem_rdata_i;
    end
    assign ptr_o[g*BYTE_W +: BYTE_W] =
      (active_q && mem_valid_i && idx_q == 2'(g)) ? mem_rdata_i : byte_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      len_q    <= 2'd2;
      base_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      idx_q    <= '0;
      len_q    <= len_i;
      base_q   <= base_i;
    end else if (active_q && mem_valid_i) begin
      idx_q <= idx_q + 2'd1;
      if (fin_o) active_q <= 1'b0;
    end
  end

  AST_READ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o && !mem_valid_i |=> mem_rd_o && $stable(mem_addr_o)); // R7
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o && mem_valid_i && !fin_o |=>
      mem_rd_o && mem_addr_o[15:0] == $past(mem_addr_o[15:0]) + 16'd1 &&
      mem_addr_o[23:16] == $past(mem_addr_o[23:16])); // R7
endmodule

// File: rtl/ea_post.sv
module ea_post
  import ea_pkg::*;
(
  input  ea_mode_e          mode_i,
  input  ea_ctx_t           ctx_i,
  input  logic [ADDR_W-1:0] ptr_i,
  output logic [ADDR_W-1:0] ea_o
);
  logic [ADDR_W-1:0] data_ptr, y_ext;

  assign data_ptr = {ctx_i.db, ptr_i[WORD_W-1:0]};
  assign y_ext    = {8'h00, ctx_i.y};

  always_comb begin
    unique case (mode_i)
      M_ABS_X_IND, M_ABS_IND:     ea_o = {ctx_i.pb, ptr_i[WORD_W-1:0]};
      M_ABS_IND_L, M_DIR_IND_L:   ea_o = ptr_i;
      M_DIR_IND_L_Y:              ea_o = ptr_i + y_ext;
      M_DIR_IND_Y, M_STK_IND_Y:   ea_o = data_ptr + y_ext;
      default:                    ea_o = data_ptr;
    endcase
  end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic [4:0]  mode_i,
  input  logic [23:0] opnd_i,
  input  logic [15:0] pc_i,
  input  logic [7:0]  pb_i,
  input  logic [7:0]  db_i,
  input  logic [15:0] d_i,
  input  logic [15:0] s_i,
  input  logic [15:0] x_i,
  input  logic [15:0] y_i,
  output logic        ready_o,
  output logic        done_o,
  output logic [23:0] ea_o,
  output logic [1:0]  pc_inc_o,
  output logic [1:0]  extra_cyc_o,
  output logic        mem_rd_o,
  output logic [23:0] mem_addr_o,
  input  logic [7:0]  mem_rdata_i,
  input  logic        mem_valid_i
);
  typedef enum logic {S_IDLE, S_FETCH} st_e;

  st_e               st_q;
  ea_mode_e          mode_in, mode_q;
  ea_ctx_t           ctx_q;
  logic              accept, need_ptr, fin;
  logic [1:0]        ptr_len, pc_inc, extra;
  logic [ADDR_W-1:0] pre_ea, ptr_addr, post_ea;
  logic [PTR_MAX*BYTE_W-1:0] ptr_val;
  logic              done_q;
  logic [ADDR_W-1:0] ea_q;
  logic [1:0]        inc_q, extra_q;

  assign mode_in = (mode_i > 5'd21) ? M_IMM8 : ea_mode_e'(mode_i);
  assign ready_o = (st_q == S_IDLE);
  assign accept  = req_i && ready_o;

  ea_pre u_pre (
    .mode_i(mode_in), .opnd_i(opnd_i), .pc_i(pc_i), .pb_i(pb_i), .db_i(db_i),
    .d_i(d_i), .s_i(s_i), .x_i(x_i), .y_i(y_i),
    .ea_o(pre_ea), .need_ptr_o(need_ptr), .ptr_len_o(ptr_len),
    .ptr_addr_o(ptr_addr), .pc_inc_o(pc_inc), .extra_o(extra)
  );

  ea_ptr_fetch #(.NBYTES(PTR_MAX)) u_fetch (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(accept && need_ptr),
    .base_i(ptr_addr), .len_i(ptr_len), .mem_valid_i(mem_valid_i),
    .mem_rdata_i(mem_rdata_i), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
    .fin_o(fin), .ptr_o(ptr_val)
  );

  ea_post u_post (.mode_i(mode_q), .ctx_i(ctx_q), .ptr_i(ptr_val), .ea_o(post_ea));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      mode_q  <= M_IMM8;
      ctx_q   <= '0;
      done_q  <= 1'b0;
      ea_q    <= '0;
      inc_q   <= '0;
      extra_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        inc_q   <= pc_inc;
        extra_q <= extra;
        if (need_ptr) begin
          st_q   <= S_FETCH;
          mode_q <= mode_in;
          ctx_q  <= '{pb: pb_i, db: db_i, y: y_i};
        end else begin
          ea_q   <= pre_ea;
          done_q <= 1'b1;
        end
      end else if (st_q == S_FETCH && fin) begin
        ea_q   <= post_ea;
        done_q <= 1'b1;
        st_q   <= S_IDLE;
      end
    end
  end

  assign done_o      = done_q;
  assign ea_o        = ea_q;
  assign pc_inc_o    = inc_q;
  assign extra_cyc_o = extra_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
  AST_FAST_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !need_ptr |=> done_o && ready_o); // R11
  AST_IDLE_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !mem_rd_o); // R7
  AST_FETCH_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> !ready_o && !done_o); // R11
  AST_ZERO_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o && mode_q != M_ABS_X_IND |-> mem_addr_o[23:16] == 8'h00); // R9
endmodule

// File: tb/ea_gen_tb_top.sv
module ea_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0;
  logic [4:0] mode = '0;
  logic [23:0] opnd = '0;
  logic [15:0] pc = '0, d = '0, s = '0, x = '0, y = '0;
  logic [7:0] pb = '0, db = '0;
  logic ready, done, mrd, mvalid = 1'b0;
  logic [23:0] ea, maddr;
  logic [1:0] pinc, extra;
  logic [7:0] mdata = '0;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ea_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .mode_i(mode), .opnd_i(opnd),
    .pc_i(pc), .pb_i(pb), .db_i(db), .d_i(d), .s_i(s), .x_i(x), .y_i(y),
    .ready_o(ready), .done_o(done), .ea_o(ea), .pc_inc_o(pinc),
    .extra_cyc_o(extra), .mem_rd_o(mrd), .mem_addr_o(maddr),
    .mem_rdata_i(mdata), .mem_valid_i(mvalid)
  );

  function automatic int memf(int a);
    return ((a & 255) * 7 + ((a >> 8) & 255) * 3 + ((a >> 16) & 255) + 17) & 255;
  endfunction

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  task automatic run(int m, int op, int lat, bit poke, string r);
    int e = 0, inc = 1, ex = 0, pbank = 0, plo = 0, plen = 0, ptr = 0;
    int disp, k = 0, w, cyc = 0, a;
    int P = pb, B = db, PC = pc, D = d, S = s, X = x, Y = y;
    case (m)
      1:  begin e = P*65536 + PC; inc = 2; end
      2:  begin disp = op & 255; if (disp > 127) disp -= 256;
                e = P*65536 + ((PC + 1 + disp) & 65535); end
      3:  begin e = P*65536 + ((PC + 2 + (op & 65535)) & 65535); inc = 2; end
      4:  e = (D + (op & 255)) & 65535;
      5:  begin e = (D + (op & 255) + X) & 65535; ex = 1; end
      6:  begin e = (D + (op & 255) + Y) & 65535; ex = 1; end
      7:  begin e = B*65536 + (op & 65535); inc = 2; end
      8:  begin e = (B*65536 + (op & 65535) + X) & 24'hFFFFFF; inc = 2; end
      9:  begin e = (B*65536 + (op & 65535) + Y) & 24'hFFFFFF; inc = 2; end
      10: begin e = op & 24'hFFFFFF; inc = 3; end
      11: begin e = (op + X) & 24'hFFFFFF; inc = 3; end
      12: begin pbank = P; plo = ((op & 65535) + X) & 65535; plen = 2; inc = 2; end
      13: begin plo = op & 65535; plen = 2; inc = 2; end
      14: begin plo = op & 65535; plen = 3; inc = 2; end
      15, 16: begin plo = (D + (op & 255)) & 65535; plen = 2; end
      17, 18: begin plo = (D + (op & 255)) & 65535; plen = 3; end
      19: begin plo = (D + (op & 255) + X) & 65535; plen = 2; ex = 1; end
      20: begin e = (S + (op & 255)) & 65535; ex = 1; end
      21: begin plo = (S + (op & 255)) & 65535; plen = 2; ex = 2; end
      default: e = P*65536 + PC;
    endcase
    for (int i = 0; i < plen; i++)
      ptr |= memf(pbank*65536 + ((plo + i) & 65535)) << (8*i);
    case (m)
      12, 13: e = P*65536 + ptr;
      14, 17: e = ptr;
      15, 19: e = B*65536 + ptr;
      16, 21: e = (B*65536 + ptr + Y) & 24'hFFFFFF;
      18:     e = (ptr + Y) & 24'hFFFFFF;
      default: ;
    endcase

    @(negedge clk);
    chk("R11 ready before request", int'(ready), 1);
    mode = 5'(m); opnd = 24'(op); req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    w = lat;
    while (!done && cyc < 60) begin
      mvalid = 1'b0;
      if (poke && cyc == 0) begin
        chk("R11 busy not ready", int'(ready), 0);
        mode = 5'd0; req = 1'b1;
      end
      if (mrd) begin
        a = pbank*65536 + ((plo + k) & 65535);
        chk({r, " R7 pointer byte address"}, int'(maddr), a);
        chk("R7 read beyond pointer length", int'(k < plen), 1);
        if (w == 0) begin
          mvalid = 1'b1; mdata = 8'(memf(int'(maddr))); k++; w = lat;
        end else w--;
      end
      @(negedge clk);
      req = 1'b0;
      cyc++;
    end
    mvalid = 1'b0;
    chk({r, " R11 done strobe"}, int'(done), 1);
    if (plen == 0) chk({r, " R11 one-cycle latency"}, cyc, 0);
    chk({r, " effective address"}, int'(ea), e);
    chk({r, " pc increment"}, int'(pinc), inc);
    chk({r, " R10 extra cycles"}, int'(extra), ex);
    chk({r, " R7 bytes read"}, k, plen);
    @(negedge clk);
    chk("R11 done single cycle", int'(done), 0);
    chk("R7 no read when idle", int'(mrd), 0);
    chk("R11 result held", int'(ea), e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset done low", int'(done), 0);
    chk("R7 reset no read", int'(mrd), 0);
    chk("R11 reset ready", int'(ready), 1);
    rst_n = 1'b1;
    pc = 16'h8123; pb = 8'h7E; db = 8'h12; d = 16'h0300; s = 16'h01F0;
    x = 16'h0010; y = 16'h0020;
    run(0, 24'h0000AA, 0, 0, "R1 imm8");
    run(1, 24'h00BBAA, 0, 0, "R1 imm16");
    run(25, 24'h0, 0, 0, "R1 unused code");
    run(2, 24'h000010, 0, 0, "R2 rel8 fwd");
    run(2, 24'h0000F0, 0, 0, "R2 rel8 back");
    run(3, 24'h00FF00, 0, 0, "R2 rel16 wrap");
    run(4, 24'h000044, 0, 0, "R3 dir");
    run(5, 24'h000044, 0, 0, "R3 dir x");
    run(6, 24'h000044, 0, 0, "R3 dir y");
    run(7, 24'h001234, 0, 0, "R4 abs");
    run(10, 24'h345678, 0, 0, "R5 long");
    run(20, 24'h000005, 0, 0, "R6 stk");
    run(13, 24'h004000, 0, 0, "R8 abs ind");
    run(12, 24'h004000, 1, 1, "R8 abs x ind");
    run(14, 24'h004100, 3, 0, "R8 abs ind long");
    run(15, 24'h000012, 1, 0, "R9 dir ind");
    run(16, 24'h000012, 0, 0, "R9 dir ind y");
    run(17, 24'h000012, 2, 0, "R9 dir ind long");
    run(18, 24'h000012, 0, 1, "R9 dir ind long y");
    run(19, 24'h000012, 1, 0, "R9 dir x ind");
    run(21, 24'h000003, 3, 0, "R10 stk ind y");
    // wrap and carry corners
    d = 16'hFFF0; s = 16'hFFFE; x = 16'hFF00; y = 16'hFFF0; db = 8'hFF; pc = 16'hFFFF;
    run(4, 24'h000020, 0, 0, "R3 dir wrap");
    run(5, 24'h000020, 0, 0, "R3 dir x wrap");
    run(6, 24'h000020, 0, 0, "R3 dir y wrap");
    run(20, 24'h000004, 0, 0, "R6 stk wrap");
    run(2, 24'h000005, 0, 0, "R2 rel8 wrap");
    run(8, 24'h00FF80, 0, 0, "R4 abs x carry");
    run(9, 24'h00FF80, 0, 0, "R4 abs y carry");
    run(11, 24'hFFFF80, 0, 0, "R5 long x wrap");
    run(13, 24'h00FFFF, 1, 0, "R7 R8 ptr wrap");
    run(12, 24'h0000FF, 0, 0, "R8 abs x ind wrap");
    run(16, 24'h000010, 2, 0, "R9 ind y carry");
    run(18, 24'h000010, 0, 0, "R9 long y wrap");
    run(21, 24'h000001, 1, 1, "R10 stk ind y wrap");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule